// File: doc/BRIEF.md
# Pulse-Distance Remote-Control Frame Encoder

This block produces the on/off envelope of a pulse-distance infrared remote-control message. A single strobe on `start_i` while the block is idle captures a custom byte, a second custom byte and a data byte. The block then plays out the envelope of one full frame on `mark_o`. The frame has a long leader mark and space, then 32 payload bits, then a closing stop mark. A carrier block downstream gates its carrier with `mark_o`. This block does not modulate the carrier and does not scan keys.

The key-held flag is sampled when the frame starts. If it stays high, the encoder does not send the payload again. It follows the frame with short repeat frames. Each repeat frame is a long mark, a short space and a stop mark. Frame starts are spaced one frame period apart. If the key is released at any point, the current frame still finishes, and no further repeat frame is scheduled.

Every duration is written in microseconds and scaled by `CYC_PER_US`. One shared down-counter times the segments. A second counter measured from each frame start sets the frame pacing.

Top module: `irtx_encoder`

## Requirements
- R1: While `rst_n` is low, and immediately after it goes low, `mark_o` and `busy_o` are 0.
- R2: A `start_i` pulse sampled while idle drives `mark_o` high from the next clock edge for the leader-mark time. A leader space follows, with `mark_o` low for the leader-space time.
- R3: The 32 payload bits go out least significant bit first, byte by byte in this order: the custom byte A, then the custom byte B exactly as presented (it is not forced to the inverse of A), then the data byte, then the bitwise inverse of the data byte.
- R4: Each payload bit is a mark of the bit-mark time. It is followed by a space of the zero-space time for a 0 or the one-space time for a 1.
- R5: After the last payload bit comes one stop mark of the bit-mark time. If the key is not held, the block is idle (`busy_o` = 0, `mark_o` = 0) right after that mark.
- R6: `busy_o` is 1 from the edge that accepts a start until the edge that returns the block to idle. `mark_o` is never 1 while `busy_o` is 0.
- R7: A `start_i` pulse while busy is ignored. The byte inputs are sampled only at an accepted start, so changing them mid-frame does not alter the frame.
- R8: If the key is held, each following frame is a repeat frame: a leader mark, a repeat space, then a stop mark. Each repeat frame starts exactly one frame period after the start of the previous frame.
- R9: If the key is released during a frame, that frame completes unchanged and the block then goes idle with no further repeat frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start strobe, acted on only while idle |
| key_held_i | input | 1 | High while the key remains pressed |
| cust_a_i | input | 8 | First custom byte |
| cust_b_i | input | 8 | Second custom byte |
| data_i | input | 8 | Data byte; its inverse is sent after it |
| mark_o | output | 1 | Envelope: 1 = carrier on, 0 = space |
| busy_o | output | 1 | High while a frame or inter-frame wait is in progress |

## Verification
The assertions assume that `start_i` and `key_held_i` are synchronous to `clk`. They also assume that the configured frame period is longer than the longest full frame, so the pacing wait is never empty. The stimulus changes every input on the falling clock edge. It uses short scaled durations in which the worst-case full frame (612 cycles) fits well inside the 800-cycle period. The key-release stimulus is applied only inside a frame or before the start, never in a way that would shorten a segment.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LMARK  = 3'd1,
    ST_LSPACE = 3'd2,
    ST_RSPACE = 3'd3,
    ST_BMARK  = 3'd4,
    ST_BSPACE = 3'd5,
    ST_SMARK  = 3'd6,
    ST_GAP    = 3'd7
  } irtx_st_e;

  function automatic logic st_is_mark(input irtx_st_e s);
    return (s == ST_LMARK) || (s == ST_BMARK) || (s == ST_SMARK);
  endfunction

endpackage

// File: rtl/irtx_downcnt.sv
module irtx_downcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)           cnt_d = val_i;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/irtx_payload.sv
module irtx_payload #(
  parameter int NBITS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [NBITS-1:0] word_i,
  input  logic             shift_i,
  output logic             bit_o,
  output logic             last_o
);

  localparam int IW = $clog2(NBITS);

  logic [NBITS-1:0] sh_q, sh_d;
  logic [IW-1:0]    idx_q, idx_d;

  always_comb begin
    sh_d  = sh_q;
    idx_d = idx_q;
    if (load_i) begin
      sh_d  = word_i;
      idx_d = '0;
    end else if (shift_i) begin
      sh_d  = {1'b0, sh_q[NBITS-1:1]};
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else begin
      sh_q  <= sh_d;
      idx_q <= idx_d;
    end
  end

  assign bit_o  = sh_q[0];
  assign last_o = (idx_q == IW'(NBITS - 1));

endmodule

// File: rtl/irtx_encoder.sv
module irtx_encoder
  import irtx_pkg::*;
#(
  parameter int CYC_PER_US   = 8,
  parameter int BYTE_W       = 8,
  parameter int T_LMARK_US   = 9000,
  parameter int T_LSPACE_US  = 4500,
  parameter int T_RSPACE_US  = 2250,
  parameter int T_BMARK_US   = 560,
  parameter int T_ZSPACE_US  = 565,
  parameter int T_OSPACE_US  = 1690,
  parameter int T_PERIOD_US  = 108000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              key_held_i,
  input  logic [BYTE_W-1:0] cust_a_i,
  input  logic [BYTE_W-1:0] cust_b_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              mark_o,
  output logic              busy_o
);

  localparam int NBITS  = 4 * BYTE_W;
  localparam int LM_C   = T_LMARK_US  * CYC_PER_US;
  localparam int LS_C   = T_LSPACE_US * CYC_PER_US;
  localparam int RS_C   = T_RSPACE_US * CYC_PER_US;
  localparam int BM_C   = T_BMARK_US  * CYC_PER_US;
  localparam int ZS_C   = T_ZSPACE_US * CYC_PER_US;
  localparam int OS_C   = T_OSPACE_US * CYC_PER_US;
  localparam int PER_C  = T_PERIOD_US * CYC_PER_US;
  localparam int MAX_AB = (LM_C > LS_C) ? LM_C : LS_C;
  localparam int MAX_CD = (RS_C > BM_C) ? RS_C : BM_C;
  localparam int MAX_EF = (ZS_C > OS_C) ? ZS_C : OS_C;
  localparam int MAX_G  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int SEG_MX = (MAX_G > MAX_EF) ? MAX_G : MAX_EF;
  localparam int SEG_W  = $clog2(SEG_MX + 1);
  localparam int PER_W  = $clog2(PER_C + 1);

  localparam logic [SEG_W-1:0] LM_V = SEG_W'(LM_C - 1);
  localparam logic [SEG_W-1:0] LS_V = SEG_W'(LS_C - 1);
  localparam logic [SEG_W-1:0] RS_V = SEG_W'(RS_C - 1);
  localparam logic [SEG_W-1:0] BM_V = SEG_W'(BM_C - 1);
  localparam logic [SEG_W-1:0] ZS_V = SEG_W'(ZS_C - 1);
  localparam logic [SEG_W-1:0] OS_V = SEG_W'(OS_C - 1);
  localparam logic [PER_W-1:0] PER_V = PER_W'(PER_C - 1);

  irtx_st_e          st_q, st_d;
  logic              mark_q, busy_q, rep_q, rep_d, full_q, full_d;
  logic              seg_ld, per_ld, seg_zero, per_zero;
  logic [SEG_W-1:0]  seg_val;
  logic              pay_ld, pay_shift, pay_bit, pay_last;
  logic [NBITS-1:0]  pay_word;

  assign pay_word = {~data_i, data_i, cust_b_i, cust_a_i};

  irtx_downcnt #(.W(SEG_W)) u_seg (
    .clk(clk), .rst_n(rst_n), .load_i(seg_ld), .val_i(seg_val), .zero_o(seg_zero)
  );

  irtx_downcnt #(.W(PER_W)) u_per (
    .clk(clk), .rst_n(rst_n), .load_i(per_ld), .val_i(PER_V), .zero_o(per_zero)
  );

  irtx_payload #(.NBITS(NBITS)) u_pay (
    .clk(clk), .rst_n(rst_n), .load_i(pay_ld), .word_i(pay_word),
    .shift_i(pay_shift), .bit_o(pay_bit), .last_o(pay_last)
  );

  // next-state and segment scheduling
  always_comb begin
    st_d      = st_q;
    seg_ld    = 1'b0;
    seg_val   = '0;
    per_ld    = 1'b0;
    pay_ld    = 1'b0;
    pay_shift = 1'b0;
    full_d    = full_q;
    rep_d     = rep_q & key_held_i;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d    = ST_LMARK;
        seg_ld  = 1'b1;
        seg_val = LM_V;
        per_ld  = 1'b1;
        pay_ld  = 1'b1;
        full_d  = 1'b1;
        rep_d   = key_held_i;
      end
      ST_LMARK: if (seg_zero) begin
        seg_ld = 1'b1;
        if (full_q) begin
          st_d    = ST_LSPACE;
          seg_val = LS_V;
        end else begin
          st_d    = ST_RSPACE;
          seg_val = RS_V;
        end
      end
      ST_LSPACE: if (seg_zero) begin
        st_d    = ST_BMARK;
        seg_ld  = 1'b1;
        seg_val = BM_V;
      end
      ST_BMARK: if (seg_zero) begin
        st_d    = ST_BSPACE;
        seg_ld  = 1'b1;
        seg_val = pay_bit ? OS_V : ZS_V;
      end
      ST_BSPACE: if (seg_zero) begin
        pay_shift = 1'b1;
        seg_ld    = 1'b1;
        seg_val   = BM_V;
        st_d      = pay_last ? ST_SMARK : ST_BMARK;
      end
      ST_RSPACE: if (seg_zero) begin
        st_d    = ST_SMARK;
        seg_ld  = 1'b1;
        seg_val = BM_V;
      end
      ST_SMARK: if (seg_zero) begin
        st_d = rep_d ? ST_GAP : ST_IDLE;
      end
      ST_GAP: begin
        if (!rep_d) begin
          st_d = ST_IDLE;
        end else if (per_zero) begin
          st_d    = ST_LMARK;
          seg_ld  = 1'b1;
          seg_val = LM_V;
          per_ld  = 1'b1;
          full_d  = 1'b0;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mark_q <= 1'b0;
      busy_q <= 1'b0;
      rep_q  <= 1'b0;
      full_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      mark_q <= st_is_mark(st_d);
      busy_q <= (st_d != ST_IDLE);
      rep_q  <= rep_d;
      full_q <= full_d;
    end
  end

  assign mark_o = mark_q;
  assign busy_o = busy_q;

endmodule

// File: rtl/irtx_encoder_chk.sv
module irtx_encoder_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic key_held_i,
  input logic mark_o,
  input logic busy_o
);

  // R6: no carrier envelope outside a busy period
  a_r6_mark_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mark_o |-> busy_o);

  // R2: an accepted start opens the leader mark on the next edge
  a_r2_start_opens_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (mark_o && busy_o));

  // R5: the idle state holds without a start strobe
  a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> !busy_o);

  // R9: busy ends only after a stop mark or on a key release
  a_r9_busy_end_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> ($past(mark_o) || !$past(key_held_i)));

endmodule

bind irtx_encoder irtx_encoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .key_held_i(key_held_i),
  .mark_o(mark_o), .busy_o(busy_o)
);

// File: tb/irtx_encoder_bench.sv
module irtx_encoder_bench;

  localparam int LM = 64, LS = 32, RS = 16, BM = 4, ZS = 4, OS = 12, PER = 800;

  logic clk, rst_n, start_i, key_held_i, mark_o, busy_o;
  logic [7:0] cust_a_i, cust_b_i, data_i;
  int ntests = 0, nfail = 0;

  localparam logic [23:0] VEC [0:3] = '{24'h00FF00, 24'hA55A3C, 24'h1234FF, 24'hFFFF81};

  irtx_encoder #(
    .CYC_PER_US(1), .BYTE_W(8), .T_LMARK_US(LM), .T_LSPACE_US(LS), .T_RSPACE_US(RS),
    .T_BMARK_US(BM), .T_ZSPACE_US(ZS), .T_OSPACE_US(OS), .T_PERIOD_US(PER)
  ) u_irtx_encoder (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .key_held_i(key_held_i),
    .cust_a_i(cust_a_i), .cust_b_i(cust_b_i), .data_i(data_i),
    .mark_o(mark_o), .busy_o(busy_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic seg(input logic lvl, input int len, input string rq);
    int bad = 0;
    logic gm = 1'b0, gb = 1'b0;
    for (int i = 0; i < len; i++) begin
      if (mark_o !== lvl || busy_o !== 1'b1) begin
        if (bad == 0) begin gm = mark_o; gb = busy_o; end
        bad++;
      end
      @(negedge clk);
    end
    ntests++;
    if (bad != 0) begin
      nfail++;
      $display("FAIL %s: mark=%b busy=%b expected mark=%b busy=1 (len %0d, %0d bad)",
               rq, gm, gb, lvl, len, bad);
    end
  endtask

  task automatic check_idle(input string rq);
    ntests++;
    if (mark_o !== 1'b0 || busy_o !== 1'b0) begin
      nfail++;
      $display("FAIL %s: mark=%b busy=%b expected mark=0 busy=0", rq, mark_o, busy_o);
    end
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  function automatic logic [31:0] mk_word(input logic [7:0] a, b, d);
    return {~d, d, b, a};
  endfunction

  function automatic int frame_len(input logic [31:0] w);
    int t = LM + LS + BM;
    for (int k = 0; k < 32; k++) t += BM + (w[k] ? OS : ZS);
    return t;
  endfunction

  task automatic payload_and_stop(input logic [31:0] w);
    for (int k = 0; k < 32; k++) begin
      seg(1'b1, BM, "R4");
      seg(1'b0, w[k] ? OS : ZS, "R3");
    end
    seg(1'b1, BM, "R5");
  endtask

  initial begin
    logic [31:0] w;
    rst_n = 1'b0; start_i = 1'b0; key_held_i = 1'b0;
    cust_a_i = '0; cust_b_i = '0; data_i = '0;
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");

    // table of byte vectors, key released: one full frame each
    for (int v = 0; v < 4; v++) begin
      {cust_a_i, cust_b_i, data_i} = VEC[v];
      w = mk_word(VEC[v][23:16], VEC[v][15:8], VEC[v][7:0]);
      pulse_start();
      seg(1'b1, LM, "R2");
      seg(1'b0, LS, "R2");
      payload_and_stop(w);
      check_idle("R5");
      repeat (3) @(negedge clk);
    end

    // R7: start while busy ignored, byte inputs latched at start
    cust_a_i = 8'h3C; cust_b_i = 8'h77; data_i = 8'h0F;
    w = mk_word(8'h3C, 8'h77, 8'h0F);
    pulse_start();
    seg(1'b1, LM, "R2");
    seg(1'b0, 10, "R7");
    start_i = 1'b1; cust_a_i = 8'hFF; cust_b_i = 8'h00; data_i = 8'hAA;
    seg(1'b0, 1, "R7");
    start_i = 1'b0;
    seg(1'b0, LS - 11, "R7");
    payload_and_stop(w);
    check_idle("R7");
    repeat (2) @(negedge clk);

    // R8 / R9: key held, repeats paced by the period, release in second repeat
    cust_a_i = 8'h81; cust_b_i = 8'h7E; data_i = 8'hC3;
    w = mk_word(8'h81, 8'h7E, 8'hC3);
    key_held_i = 1'b1;
    pulse_start();
    seg(1'b1, LM, "R2");
    seg(1'b0, LS, "R2");
    payload_and_stop(w);
    seg(1'b0, PER - frame_len(w), "R8");
    seg(1'b1, LM, "R8");
    seg(1'b0, RS, "R8");
    seg(1'b1, BM, "R8");
    seg(1'b0, PER - (LM + RS + BM), "R8");
    seg(1'b1, 10, "R9");
    key_held_i = 1'b0;
    seg(1'b1, LM - 10, "R9");
    seg(1'b0, RS, "R9");
    seg(1'b1, BM, "R9");
    check_idle("R9");
    repeat (PER) @(negedge clk);
    check_idle("R9");

    // R1: asynchronous reset in mid-frame, then normal restart
    pulse_start();
    seg(1'b1, 20, "R2");
    rst_n = 1'b0;
    #1;
    check_idle("R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");
    cust_a_i = 8'h01; cust_b_i = 8'h02; data_i = 8'h03;
    w = mk_word(8'h01, 8'h02, 8'h03);
    pulse_start();
    seg(1'b1, LM, "R6");
    seg(1'b0, LS, "R6");
    payload_and_stop(w);
    check_idle("R6");

    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    ntests++;
    nfail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

endmodule